// File: doc/BRIEF.md
# Signed/Unsigned Array Multiplier

This block multiplies two W-bit operands (W = 8 by default) and returns the full 2W-bit product with no truncation. A single mode bit picks the interpretation of both operands: plain unsigned binary, or two's complement. All partial-product rows are formed and summed in one pass, without iterating over multiplier bits.

Each row k is the multiplicand ANDed with multiplier bit k, shifted left by k places. In two's-complement mode, the row built from the sign bit has negative weight. This is handled by inverting the product terms that mix exactly one sign bit with a non-sign bit. Two constant ones are then added at bit W and bit 2W-1, and the sum is taken modulo 2^(2W). No row is sign-extended and no result is negated. A parameter places an optional output register after the sum. The register captures on the rising clock edge and clears on a synchronous active-high reset.

Top module: `sarray_mult`

## Requirements
- R1: With mode = 0, the product equals the unsigned product of the two operands, as a full 16-bit value.
- R2: With mode = 1, the product equals the two's-complement product of the two operands, given as a 16-bit two's-complement value.
- R3: With mode = 1, operands 0x80 and 0x80 (-128 times -128) give 0x4000 (+16384).
- R4: With mode = 1, operands 0x80 and 0x7F (-128 times 127) give 0xC080 (-16256).
- R5: With mode = 0, operands 0xFF and 0xFF give 0xFE01.
- R6: When either operand is zero, the product is 0x0000 in both modes.
- R7: The mode bit selects the interpretation: 0 means unsigned and 1 means two's complement. For example, 0x80 times 0x02 gives 0x0100 with mode 0 and 0xFF00 with mode 1.
- R8: With OUT_REG = 1, the product for inputs held across a rising edge appears after that edge. With OUT_REG = 1, a rising edge with rst high clears the product to zero.
- R9: With OUT_REG = 0, the product follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mode | input | 1 | 0 = unsigned, 1 = two's complement on both operands |
| a | input | W | Multiplicand |
| b | input | W | Multiplier |
| prod | output | 2W | Full-width product |

## Verification
The bench builds two copies of the block at W = 8. One has OUT_REG = 1 and is checked one rising edge after each input change. The other has OUT_REG = 0 and is checked a moment after the inputs settle. With both copies, the same operand stream exercises the correction-constant path and also confirms the one-cycle latency and the synchronous clear. W = 8 keeps the corner operands 0x80, 0x7F and 0xFF directly reachable, which matters because those are the operands that stress the complemented sign terms.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_TC  = 1'b1
  } mul_mode_e;

  // A term is inverted in two's-complement mode when exactly one of its
  // two indices is the sign position.
  function automatic logic tc_flip(input int col, input int row, input int w);
    return (col == w - 1) != (row == w - 1);
  endfunction

endpackage

// File: rtl/pp_gen.sv
module pp_gen
  import mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  mul_mode_e      mode_i,
  output logic [W*W-1:0] terms_o   // row r occupies bits [r*W +: W]
);

  localparam int NTERM = W * W;

  logic tc;
  assign tc = (mode_i == MODE_TC);

  genvar r, c;
  generate
    for (r = 0; r < W; r++) begin : g_row
      for (c = 0; c < W; c++) begin : g_col
        localparam logic FLIP = tc_flip(c, r, W);
        if (FLIP) begin : g_inv
          assign terms_o[r*W + c] = (a_i[c] & b_i[r]) ^ tc;
        end else begin : g_pass
          assign terms_o[r*W + c] = a_i[c] & b_i[r];
        end
      end
    end
  endgenerate

  initial begin
    if (NTERM < 4) $error("pp_gen: width too small");
  end

endmodule

// File: rtl/pp_sum.sv
module pp_sum
  import mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W*W-1:0] terms_i,
  input  mul_mode_e      mode_i,
  output logic [2*W-1:0] sum_o
);

  localparam int PW = 2 * W;
  localparam logic [PW-1:0] CORR = (PW'(1) << W) | (PW'(1) << (PW - 1));

  logic [PW-1:0] acc [0:W];

  // Seed the chain with the correction ones when in two's-complement mode.
  assign acc[0] = (mode_i == MODE_TC) ? CORR : '0;

  genvar r;
  generate
    for (r = 0; r < W; r++) begin : g_add
      logic [PW-1:0] row_ext;
      assign row_ext    = {{W{1'b0}}, terms_i[r*W +: W]} << r;
      assign acc[r + 1] = acc[r] + row_ext;
    end
  endgenerate

  assign sum_o = acc[W];

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int PW  = 16,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);

  generate
    if (REG) begin : g_reg
      logic [PW-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d_i;
      end
      assign q_o = q_r;

      // R8
      rst_clears_chk: assert property (@(posedge clk) rst |=> (q_o == '0));

      // R8
      one_cycle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q_o == $past(d_i)));
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/sarray_mult.sv
module sarray_mult
  import mul_pkg::*;
#(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  mul_mode_e      mode_e;
  logic [W*W-1:0] terms;
  logic [PW-1:0]  sum_w;

  assign mode_e = mul_mode_e'(mode);

  pp_gen #(.W(W)) u_gen (
    .a_i     (a),
    .b_i     (b),
    .mode_i  (mode_e),
    .terms_o (terms)
  );

  pp_sum #(.W(W)) u_sum (
    .terms_i (terms),
    .mode_i  (mode_e),
    .sum_o   (sum_w)
  );

  out_stage #(.PW(PW), .REG(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .d_i (sum_w),
    .q_o (prod)
  );

  // R1
  uns_prod_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 1'b0) |-> (sum_w == ({{W{1'b0}}, a} * {{W{1'b0}}, b})));

  // R2
  tc_prod_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 1'b1) |-> (sum_w ==
      PW'($signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b}))));

  // R6
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    ((a == '0) || (b == '0)) |-> (sum_w == '0));

endmodule

// File: tb/tb_sarray_mult.sv
module tb_sarray_mult;

  localparam int  W      = 8;
  localparam int  PW     = 2 * W;
  localparam time CLK_PD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic [PW-1:0] prod_r;
  logic [PW-1:0] prod_c;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [PW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb_q[$];

  always #(CLK_PD/2) clk = ~clk;

  sarray_mult #(.W(W), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst (rst), .mode (mode), .a (a), .b (b), .prod (prod_r)
  );

  sarray_mult #(.W(W), .OUT_REG(1'b0)) dut_comb (
    .clk (clk), .rst (rst), .mode (mode), .a (a), .b (b), .prod (prod_c)
  );

  function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] x,
                                              input logic [W-1:0] y,
                                              input logic m);
    int xi, yi;
    if (m) begin
      xi = int'($signed(x));
      yi = int'($signed(y));
    end else begin
      xi = int'(x);
      yi = int'(y);
    end
    return PW'(xi * yi);
  endfunction

  task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp,
                       input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply operands, check the combinational copy, queue the
  // registered expectation.
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic m, input string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; mode = m;
    it.exp = ref_prod(x, y, m);
    it.tag = tag;
    sb_q.push_back(it);
    #1;
    check(prod_c, it.exp, {tag, " R9 comb"});
  endtask

  // Monitor: registered result is valid just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(prod_r, it.exp, {it.tag, " R8 reg"});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R8)
    a = 8'hA5; b = 8'h3C; mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(prod_r, '0, "R8 reset state");
    @(negedge clk);
    rst = 1'b0;

    // Corner cases
    drive(8'h80, 8'h80, 1'b1, "R3 -128*-128");
    drive(8'h80, 8'h7F, 1'b1, "R4 -128*127");
    drive(8'h7F, 8'h80, 1'b1, "R4 127*-128");
    drive(8'hFF, 8'hFF, 1'b0, "R5 255*255");
    drive(8'h00, 8'hFF, 1'b0, "R6 zero a uns");
    drive(8'hFF, 8'h00, 1'b0, "R6 zero b uns");
    drive(8'h00, 8'h80, 1'b1, "R6 zero a tc");
    drive(8'h80, 8'h00, 1'b1, "R6 zero b tc");
    drive(8'h80, 8'h02, 1'b0, "R7 mode0");
    drive(8'h80, 8'h02, 1'b1, "R7 mode1");
    drive(8'hFF, 8'hFF, 1'b1, "R2 -1*-1");
    drive(8'hFF, 8'h01, 1'b1, "R2 -1*1");

    // Walking ones in both modes
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        drive(8'(1 << i), 8'(1 << j), 1'b0, "R1 walk");
        drive(8'(1 << i), 8'(1 << j), 1'b1, "R2 walk");
      end
    end

    // Pseudo-random stream, modes interleaved
    begin
      logic [31:0] s;
      s = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        if (s[0]) drive(s[15:8], s[27:20], 1'b1, "R2 mixed");
        else      drive(s[15:8], s[27:20], 1'b0, "R1 mixed");
      end
    end

    // Drain the scoreboard
    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);

    // Synchronous clear mid-run (R8)
    @(negedge clk);
    a = 8'h77; b = 8'h99; mode = 1'b0;
    @(posedge clk);
    #1;
    check(prod_r, ref_prod(8'h77, 8'h99, 1'b0), "R8 capture before clear");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(prod_r, '0, "R8 synchronous clear");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(prod_r, ref_prod(8'h77, 8'h99, 1'b0), "R8 resume after clear");

    finish_run();
  end

endmodule